// File: doc/BRIEF.md
# Host Burst Command Engine with FIFO Interrupts

This block sits between a host register bus and a client port and moves 32-bit words in bursts. Software programs a 16-bit control word with a burst length, a direction bit, a repeat bit and a client soft-reset bit. A nonzero length written while the engine is idle starts a command. A write burst hands that many words from the write FIFO to the client. A read burst accepts that many words from the client into the read FIFO. The host fills the write FIFO and drains the read FIFO through word-wide push and pop ports.

A second register holds three interrupt enables and an 8-bit threshold. The threshold is counted in pairs of write-FIFO slots: the partial-empty flag is raised when the free slots in the write FIFO number at least twice the threshold. A read-only status register shows the partial-empty flag, the write-FIFO-empty flag and the read-data-available flag. The interrupt output is the OR of each flag ANDed with its enable.

In repeat mode a finished write burst reloads its length, and the engine stays busy until software clears the mode bit or asserts soft reset. While soft reset is held, the client reset output stays high, both FIFOs are held empty and any burst in progress is dropped.

Top module: `bcc_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x0000, the interrupt register (address 1) reads 0x2000 and the interrupt output is low.
- R2: Control bits 15:13 and bit 1 and interrupt-register bits 6:2 read as 0 whatever is written. All other bits read back as written.
- R3: A control write with burst length (bits 12:4) of 0 launches no transfer in either direction.
- R4: A write burst of length N (bit 0 = 0) delivers exactly N words to the client, in FIFO order, and then stops even if more words remain queued.
- R5: A read burst of length N (bit 0 = 1) accepts exactly N client words into the read FIFO. The host pops them back in arrival order.
- R6: A length of 256 (control value 0x1000) moves 256 words.
- R7: With control bit 3 set, a completed write burst reloads the same length. After bit 3 is cleared, the burst in progress finishes and no further burst follows.
- R8: Control bit 2 drives the client reset output from the cycle after the write. While it is set, both FIFOs are emptied, host pushes are dropped and the burst in progress is cancelled. Clearing the bit does not resume the cancelled burst.
- R9: Status bit 7 is 1 exactly when (256 − write-FIFO occupancy) ≥ 2 × threshold, where the threshold is interrupt-register bits 15:8.
- R10: The interrupt output equals (bit7 & status7) | (bit1 & status1) | (bit0 & status0), using the enables from the interrupt register.
- R11: Status register (address 2) bit 1 is 1 when the write FIFO is empty, and bit 0 is 1 when the read FIFO holds data. All other status bits are 0.
- R12: A nonzero-length control write while a burst is active does not change the remaining length of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 control, 1 interrupt, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| host_wr_push | input | 1 | Push a word into the write FIFO |
| host_wr_data | input | 32 | Word to push |
| host_wr_full | output | 1 | Write FIFO full |
| host_rd_pop | input | 1 | Pop the head of the read FIFO |
| host_rd_data | output | 32 | Read FIFO head word |
| host_rd_valid | output | 1 | Read FIFO not empty |
| cli_reset | output | 1 | Soft reset to the client |
| cli_wvalid | output | 1 | Write word offered to the client |
| cli_wdata | output | 32 | Write word |
| cli_wready | input | 1 | Client takes the write word |
| cli_rvalid | input | 1 | Client offers a read word |
| cli_rdata | input | 32 | Read word from the client |
| cli_rready | output | 1 | Engine accepts the read word |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach is a repeat-mode write burst that has reloaded and is partly done when software clears the mode bit. The only evidence at the ports is how many later words still drain out. The bench enables repeat mode with a length of 3 and queues seven words, which is two full bursts plus one word. It then clears the mode and queues three more words, and expects exactly two of them to leave. Soft reset in the middle of a stalled burst is reached the same way: the client is held not-ready while words are queued.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int WORD_W     = 32;
    localparam int REG_W      = 16;
    localparam int LEN_W      = 9;
    localparam int THR_W      = 8;
    localparam int FIFO_DEPTH = 256;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_IRQ  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam logic [REG_W-1:0] CTRL_RESET = 16'h0000;
    localparam logic [REG_W-1:0] IRQ_RESET  = 16'h2000;
    localparam logic [REG_W-1:0] CTRL_MASK  = 16'h1FFD;
    localparam logic [REG_W-1:0] IRQ_MASK   = 16'hFF83;

    typedef struct packed {
        logic [2:0]       pad_hi;
        logic [LEN_W-1:0] len;
        logic             repeat_wr;
        logic             soft_rst;
        logic             pad_lo;
        logic             is_read;
    } ctrl_t;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             pe_en;
        logic [4:0]       pad;
        logic             we_en;
        logic             ra_en;
    } irq_cfg_t;

    typedef struct packed {
        logic part_empty;
        logic wr_empty;
        logic rd_avail;
    } stat_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_WRITE = 2'd1,
        ENG_READ  = 2'd2
    } eng_state_e;

    function automatic logic [REG_W-1:0] pack_stat(input stat_t s);
        return {8'h00, s.part_empty, 5'b00000, s.wr_empty, s.rd_avail};
    endfunction

endpackage

// File: rtl/bcc_fifo.sv
module bcc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= wptr + AW'(1);
            if (do_pop)  rptr <= rptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);
endmodule

// File: rtl/bcc_regs.sv
module bcc_regs
    import bcc_pkg::*;
#(
    parameter int LW = LEN_W,
    parameter int TW = THR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  stat_t             stat,
    output logic              soft_rst,
    output logic              repeat_wr,
    output logic [TW-1:0]     thr,
    output logic              launch,
    output logic [LW-1:0]     launch_len,
    output logic              launch_rd,
    output logic              irq
);
    ctrl_t    ctrl_q, wr_ctrl;
    irq_cfg_t cfg_q;
    logic     ctrl_we, cfg_we;

    assign wr_ctrl = ctrl_t'(wdata);
    assign ctrl_we = sel && wr && (addr == ADDR_CTRL);
    assign cfg_we  = sel && wr && (addr == ADDR_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
            cfg_q  <= irq_cfg_t'(IRQ_RESET);
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_t'(wdata & CTRL_MASK);
            if (cfg_we)  cfg_q  <= irq_cfg_t'(wdata & IRQ_MASK);
        end
    end

    assign launch     = ctrl_we && (wr_ctrl.len != '0) && !wr_ctrl.soft_rst;
    assign launch_len = wr_ctrl.len;
    assign launch_rd  = wr_ctrl.is_read;
    assign soft_rst   = ctrl_q.soft_rst;
    assign repeat_wr  = ctrl_q.repeat_wr;
    assign thr        = cfg_q.thr;

    assign irq = (cfg_q.pe_en && stat.part_empty) ||
                 (cfg_q.we_en && stat.wr_empty)   ||
                 (cfg_q.ra_en && stat.rd_avail);

    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = REG_W'(ctrl_q);
            ADDR_IRQ:  rdata = REG_W'(cfg_q);
            ADDR_STAT: rdata = pack_stat(stat);
            default:   rdata = '0;
        endcase
    end

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (REG_W'(ctrl_q) == ($past(wdata) & CTRL_MASK)));
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (REG_W'(cfg_q) == ($past(wdata) & IRQ_MASK)));
endmodule

// File: rtl/bcc_engine.sv
module bcc_engine
    import bcc_pkg::*;
#(
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          srst,
    input  logic          launch,
    input  logic [LW-1:0] len,
    input  logic          is_read,
    input  logic          repeat_wr,
    input  logic          beat,
    output logic          busy_wr,
    output logic          busy_rd
);
    eng_state_e    state;
    logic [LW-1:0] remain, len_q;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            state  <= ENG_IDLE;
            remain <= '0;
            len_q  <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (launch) begin
                        state  <= is_read ? ENG_READ : ENG_WRITE;
                        remain <= len;
                        len_q  <= len;
                    end
                end
                default: begin
                    if (beat) begin
                        if (remain == LW'(1)) begin
                            if (state == ENG_WRITE && repeat_wr) begin
                                remain <= len_q;
                            end else begin
                                state  <= ENG_IDLE;
                                remain <= '0;
                            end
                        end else begin
                            remain <= remain - LW'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign busy_wr = (state == ENG_WRITE) && !srst;
    assign busy_rd = (state == ENG_READ) && !srst;

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_IDLE && !launch) |=> (state == ENG_IDLE));
    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (state != ENG_IDLE && beat && remain > LW'(1) && !srst)
            |=> (remain == $past(remain) - LW'(1)));
    p_srst_idle_r8: assert property (@(posedge clk) disable iff (rst)
        srst |=> (state == ENG_IDLE));
    p_busy_ignore_r12: assert property (@(posedge clk) disable iff (rst)
        (state != ENG_IDLE && launch && !beat && !srst) |=> $stable(remain));
endmodule

// File: rtl/bcc_top.sv
module bcc_top
    import bcc_pkg::*;
#(
    parameter int WW    = WORD_W,
    parameter int DEPTH = FIFO_DEPTH,
    parameter int LW    = LEN_W,
    parameter int TW    = THR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              host_wr_push,
    input  logic [WW-1:0]     host_wr_data,
    output logic              host_wr_full,
    input  logic              host_rd_pop,
    output logic [WW-1:0]     host_rd_data,
    output logic              host_rd_valid,
    output logic              cli_reset,
    output logic              cli_wvalid,
    output logic [WW-1:0]     cli_wdata,
    input  logic              cli_wready,
    input  logic              cli_rvalid,
    input  logic [WW-1:0]     cli_rdata,
    output logic              cli_rready,
    output logic              irq
);
    localparam int CW   = $clog2(DEPTH) + 1;
    localparam int CMPW = (CW > TW + 1) ? CW : TW + 1;

    logic          srst, rep, launch, launch_rd;
    logic [LW-1:0] launch_len;
    logic [TW-1:0] thr;
    logic          busy_wr, busy_rd, beat;
    logic          wf_full, wf_empty, rf_full, rf_empty;
    logic [CW-1:0] wf_count, rf_count, free_slots;
    logic [TW:0]   need_slots;
    stat_t         stat;

    bcc_regs #(.LW(LW), .TW(TW)) u_regs (
        .clk(clk), .rst(rst), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .stat(stat),
        .soft_rst(srst), .repeat_wr(rep), .thr(thr), .launch(launch),
        .launch_len(launch_len), .launch_rd(launch_rd), .irq(irq)
    );

    bcc_engine #(.LW(LW)) u_engine (
        .clk(clk), .rst(rst), .srst(srst), .launch(launch), .len(launch_len),
        .is_read(launch_rd), .repeat_wr(rep), .beat(beat),
        .busy_wr(busy_wr), .busy_rd(busy_rd)
    );

    bcc_fifo #(.W(WW), .DEPTH(DEPTH)) u_wfifo (
        .clk(clk), .rst(rst), .flush(srst),
        .push(host_wr_push), .din(host_wr_data),
        .pop(cli_wvalid && cli_wready), .dout(cli_wdata),
        .count(wf_count), .full(wf_full), .empty(wf_empty)
    );

    bcc_fifo #(.W(WW), .DEPTH(DEPTH)) u_rfifo (
        .clk(clk), .rst(rst), .flush(srst),
        .push(cli_rvalid && cli_rready), .din(cli_rdata),
        .pop(host_rd_pop), .dout(host_rd_data),
        .count(rf_count), .full(rf_full), .empty(rf_empty)
    );

    assign cli_reset     = srst;
    assign cli_wvalid    = busy_wr && !wf_empty;
    assign cli_rready    = busy_rd && !rf_full;
    assign beat          = (cli_wvalid && cli_wready) || (cli_rvalid && cli_rready);
    assign host_wr_full  = wf_full;
    assign host_rd_valid = !rf_empty;

    assign free_slots = CW'(DEPTH) - wf_count;
    assign need_slots = {thr, 1'b0};

    always_comb begin
        stat.part_empty = CMPW'(free_slots) >= CMPW'(need_slots);
        stat.wr_empty   = wf_empty;
        stat.rd_avail   = !rf_empty;
    end

    p_pempty_r9: assert property (@(posedge clk) disable iff (rst)
        (wf_empty && !srst) |-> (stat.part_empty || int'(thr) > DEPTH / 2));
    p_cli_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cli_reset) |-> (!cli_wvalid && !cli_rready));
    p_rfifo_bound_r5: assert property (@(posedge clk) disable iff (rst)
        rf_count <= CW'(DEPTH));
endmodule

// File: tb/test_bcc_top.sv
`timescale 1ns/1ps
module test_bcc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        host_wr_push = 1'b0;
    logic [31:0] host_wr_data = 32'h0;
    logic        host_wr_full, host_rd_pop = 1'b0, host_rd_valid;
    logic [31:0] host_rd_data;
    logic        cli_reset, cli_wvalid, cli_wready = 1'b0;
    logic [31:0] cli_wdata, cli_rdata;
    logic        cli_rvalid = 1'b0, cli_rready, irq;

    int unsigned checks = 0, errors = 0;
    int unsigned mon_checks = 0, mon_errors = 0;
    int unsigned wr_cnt = 0, rd_cnt = 0;
    int unsigned wstart = 0;
    logic [31:0] wbase = 32'h0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    assign cli_rdata = 32'hA500_0000 + rd_cnt;

    bcc_top i_bcc_top (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_wr_push(host_wr_push), .host_wr_data(host_wr_data),
        .host_wr_full(host_wr_full), .host_rd_pop(host_rd_pop),
        .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
        .cli_reset(cli_reset), .cli_wvalid(cli_wvalid), .cli_wdata(cli_wdata),
        .cli_wready(cli_wready), .cli_rvalid(cli_rvalid), .cli_rdata(cli_rdata),
        .cli_rready(cli_rready), .irq(irq)
    );

    // Client-side monitor: order of written words (R4)
    always @(posedge clk) begin
        if (!rst && cli_wvalid && cli_wready) begin
            mon_checks <= mon_checks + 1;
            if (cli_wdata !== wbase + (wr_cnt - wstart)) begin
                mon_errors <= mon_errors + 1;
                $display("FAIL R4 word order: actual %h expected %h",
                         cli_wdata, wbase + (wr_cnt - wstart));
            end
            wr_cnt <= wr_cnt + 1;
        end
        if (!rst && cli_rvalid && cli_rready) rd_cnt <= rd_cnt + 1;
    end

    function automatic bit exp_pempty(int unsigned occ, int unsigned thr);
        return (256 - occ) >= 2 * thr;
    endfunction

    function automatic bit exp_irq(logic [2:0] en, bit pe, bit we, bit ra);
        return (en[2] & pe) | (en[1] & we) | (en[0] & ra);
    endfunction

    task automatic check(input bit ok, input string req, input int unsigned act,
                         input int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    task automatic push_words(input int unsigned n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_wr_push = 1'b1; host_wr_data = base + i;
        end
        @(negedge clk);
        host_wr_push = 1'b0;
    endtask

    task automatic soft_flush();
        cli_wready = 1'b0; cli_rvalid = 1'b0;
        reg_write(2'd0, 16'h0004);
        reg_write(2'd0, 16'h0000);
    endtask

    task automatic idle(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks",
                     errors + mon_errors, checks + mon_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        int unsigned n, extra, t, k, start, to;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        reg_read(2'd0, d); check(d == 16'h0000, "R1 ctrl", d, 16'h0000);
        reg_read(2'd1, d); check(d == 16'h2000, "R1 irq cfg", d, 16'h2000);
        check(irq == 1'b0, "R1 irq", irq, 0);
        reg_read(2'd2, d); check(d == 16'h0082, "R11 status after reset", d, 16'h0082);

        // R2 reserved bits
        reg_write(2'd0, 16'hFFFF);
        reg_read(2'd0, d); check(d == 16'h1FFD, "R2 ctrl mask", d, 16'h1FFD);
        reg_write(2'd0, 16'h0000);
        reg_write(2'd1, 16'hFFFF);
        reg_read(2'd1, d); check(d == 16'hFF83, "R2 irq mask", d, 16'hFF83);
        reg_write(2'd1, 16'h2000);

        // R3 zero length launches nothing
        soft_flush();
        wbase = 32'h100; wstart = wr_cnt; start = wr_cnt;
        push_words(4, 32'h100);
        cli_wready = 1'b1;
        reg_write(2'd0, 16'h0008);
        idle(10);
        check(wr_cnt == start, "R3 no write", wr_cnt - start, 0);
        start = rd_cnt; cli_rvalid = 1'b1;
        reg_write(2'd0, 16'h0001);
        idle(10);
        check(rd_cnt == start, "R3 no read", rd_cnt - start, 0);

        // R4 random write bursts
        for (int it = 0; it < 4; it++) begin
            soft_flush();
            n = 1 + $urandom % 20; extra = 1 + $urandom % 4;
            wbase = 32'h1000 * (it + 1); wstart = wr_cnt; start = wr_cnt;
            push_words(n + extra, wbase);
            reg_write(2'd0, 16'(n << 4));
            to = 0;
            while (wr_cnt - start < n && to < 2000) begin
                @(negedge clk); cli_wready = $urandom % 2; to++;
            end
            cli_wready = 1'b1; idle(20);
            check(wr_cnt - start == n, "R4 write count", wr_cnt - start, n);
            reg_read(2'd2, d);
            check(d[1] == 1'b0, "R4 leftover words stay", d[1], 0);
        end

        // R5 random read bursts
        for (int it = 0; it < 3; it++) begin
            soft_flush();
            n = 1 + $urandom % 30; start = rd_cnt;
            reg_write(2'd0, 16'((n << 4) | 1));
            to = 0;
            while (rd_cnt - start < n && to < 2000) begin
                @(negedge clk); cli_rvalid = $urandom % 2; to++;
            end
            cli_rvalid = 1'b1; idle(20); cli_rvalid = 1'b0;
            check(rd_cnt - start == n, "R5 read count", rd_cnt - start, n);
            reg_read(2'd2, d);
            check(d[0] == 1'b1, "R11 read data available", d[0], 1);
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                host_rd_pop = 1'b1;
                #1 check(host_rd_data == 32'hA500_0000 + start + i, "R5 read order",
                         host_rd_data, 32'hA500_0000 + start + i);
            end
            @(negedge clk); host_rd_pop = 1'b0;
            #1 check(host_rd_valid == 1'b0, "R5 drained", host_rd_valid, 0);
        end

        // R6 maximum length
        soft_flush();
        wbase = 32'h0001_0000; wstart = wr_cnt; start = wr_cnt;
        push_words(256, wbase);
        check(host_wr_full == 1'b1, "R6 fifo full", host_wr_full, 1);
        reg_write(2'd0, 16'h1000);
        cli_wready = 1'b1; to = 0;
        while (wr_cnt - start < 256 && to < 1000) begin @(negedge clk); to++; end
        idle(10);
        check(wr_cnt - start == 256, "R6 count", wr_cnt - start, 256);
        reg_read(2'd2, d);
        check(d[1] == 1'b1, "R11 write fifo empty", d[1], 1);

        // R7 repeated write
        soft_flush();
        wbase = 32'h0002_0000; wstart = wr_cnt; start = wr_cnt;
        cli_wready = 1'b1;
        reg_write(2'd0, 16'h0038);
        push_words(7, wbase);
        idle(20);
        check(wr_cnt - start == 7, "R7 reload", wr_cnt - start, 7);
        reg_write(2'd0, 16'h0000);
        push_words(3, wbase + 7);
        idle(20);
        check(wr_cnt - start == 9, "R7 stop after clear", wr_cnt - start, 9);

        // R8 soft reset mid burst
        soft_flush();
        wbase = 32'h0003_0000; wstart = wr_cnt; start = wr_cnt;
        push_words(3, wbase);
        reg_write(2'd0, 16'h00A0);
        reg_write(2'd0, 16'h0004);
        check(cli_reset == 1'b1, "R8 client reset", cli_reset, 1);
        check(cli_wvalid == 1'b0, "R8 no offer", cli_wvalid, 0);
        idle(1);
        reg_read(2'd2, d); check(d[1] == 1'b1, "R8 flushed", d[1], 1);
        push_words(2, wbase);
        reg_read(2'd2, d); check(d[1] == 1'b1, "R8 push dropped", d[1], 1);
        reg_write(2'd0, 16'h0000);
        check(cli_reset == 1'b0, "R8 release", cli_reset, 0);
        cli_wready = 1'b1;
        push_words(2, wbase);
        idle(10);
        check(wr_cnt == start, "R8 burst cancelled", wr_cnt - start, 0);

        // R9 partial-empty threshold, directed edges then random
        for (int it = 0; it < 7; it++) begin
            soft_flush();
            case (it)
                0: begin t = 64; k = 128; end
                1: begin t = 64; k = 129; end
                2: begin t = 0;  k = 256; end
                default: begin t = $urandom % 160; k = $urandom % 257; end
            endcase
            reg_write(2'd1, 16'(t << 8));
            push_words(k, 32'h0);
            reg_read(2'd2, d);
            check(d[7] == exp_pempty(k, t), "R9 part empty", d[7], exp_pempty(k, t));
        end

        // R10 interrupt combinations: write fifo empty, read fifo empty
        soft_flush();
        for (int e = 0; e < 8; e++) begin
            logic [2:0] en = 3'(e);
            reg_write(2'd1, {8'hFF, en[2], 5'b0, en[1], en[0]});
            #1 check(irq == exp_irq(en, 0, 1, 0), "R10 thr high", irq, exp_irq(en, 0, 1, 0));
            reg_write(2'd1, {8'h00, en[2], 5'b0, en[1], en[0]});
            #1 check(irq == exp_irq(en, 1, 1, 0), "R10 thr zero", irq, exp_irq(en, 1, 1, 0));
        end
        reg_write(2'd0, 16'h0011);
        cli_rvalid = 1'b1; idle(4); cli_rvalid = 1'b0;
        reg_write(2'd1, 16'hFF01);
        #1 check(irq == 1'b1, "R10 read source", irq, 1);
        reg_write(2'd1, 16'hFF80);
        #1 check(irq == 1'b0, "R10 masked", irq, 0);

        // R12 launch while busy ignored
        soft_flush();
        wbase = 32'h0004_0000; wstart = wr_cnt; start = wr_cnt;
        push_words(8, wbase);
        reg_write(2'd0, 16'h0050);
        reg_write(2'd0, 16'h0020);
        cli_wready = 1'b1; idle(20);
        check(wr_cnt - start == 5, "R12 length kept", wr_cnt - start, 5);
        reg_read(2'd2, d); check(d[1] == 1'b0, "R12 rest queued", d[1], 0);

        idle(5);
        finish_run();
    end
endmodule